// File: doc/BRIEF.md
# Masked-Write Pad Configuration Register Bank

This block keeps the pad settings for up to four GPIO banks of 32 pins each. Every pin has a 2-bit function select, a 2-bit bias code and a drive-strength code. All of them sit in 32-bit registers on a simple single-cycle register bus. Software never needs a read-modify-write. The upper half-word of every write is a per-bit enable mask for the lower half-word, so one store can change a single pin's field and leave its neighbours alone.

Downstream pad logic uses the decoded per-pin outputs. These are the function select, separate pull-up and pull-down enables, and a 3-bit drive code. There is also a per-pin flag raised when a pad holds a bias code that has no meaning for it. Each 8-pin group has a fixed pad type, set by a constant parameter, and that type decides how its stored bias code is decoded. Groups marked as wide-drive store 3 bits per pin. Their 24-bit field is split over two consecutive registers.

Top module: `pinconf_regs`

## Requirements
- R1: A write changes bit i (0..15) of the addressed register only when cfg_wdata[16+i] is 1. When the mask bit is 0, the stored bit keeps its old value.
- R2: A read (cfg_sel=1, cfg_wr=0) loads cfg_rdata at the next clock edge, where it holds until the next read. cfg_rdata[15:0] is the stored word and cfg_rdata[31:16] is zero.
- R3: The function-select register of bank b, group g is at byte address b*0x10 + g*4. Pin i of the group uses bits 2*i+1:2*i. The field appears on pin_func[2*n+1:2*n], where n = b*32 + g*8 + i.
- R4: The bias register for the same bank and group is at the function-select address + 0x40, with the same 2-bit-per-pin layout.
- R5: On default-type pads, bias code 0 floats the pad, 1 enables pull-up, 2 enables pull-down and 3 is reserved.
- R6: On low-voltage pads, bias code 0 floats the pad, 1 enables pull-down, 2 floats the pad and 3 enables pull-up. Such pads never raise the error flag.
- R7: pin_pull_up and pin_pull_dn are never both 1 for a pin. A reserved code drives both low and sets pin_bias_err for that pin.
- R8: The drive registers of bank b, group g are at 0x80 + b*0x20 + g*8 (first slot) and +4 (second slot). In a narrow group, pin i uses first-slot bits 2*i+1:2*i. Its pin_drive value is that code zero-extended to 3 bits (0 = weakest).
- R9: In a wide group, pin i uses bits 3*i+2:3*i of a 24-bit field. Field bits 15:0 are the first slot. Field bits 23:16 are bits 7:0 of the second slot.
- R10: Writes to unmapped words are ignored and reads from them return 0. Unmapped words are: a nonzero cfg_addr[1:0], the second drive slot of a narrow group, and banks at or above NUM_BANKS. Bits 15:8 of a wide group's second slot also ignore writes and read 0.
- R11: After reset every stored field is 0. All pins then show function 0, floating bias, no error and drive code 0.
- R12: The pad type table is a parameter with one bit per group (index b*4+g, 1 = low-voltage). By default it marks bank 0 groups 0-1 and bank 2 groups 2-3 as low-voltage. The same stored bias code decodes differently in groups of different type.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_sel | input | 1 | Bus access strobe |
| cfg_wr | input | 1 | 1 = write, 0 = read |
| cfg_addr | input | 8 | Byte address |
| cfg_wdata | input | 32 | Write data: [31:16] bit-enable mask, [15:0] data |
| cfg_rdata | output | 32 | Registered read data |
| pin_func | output | NUM_BANKS*64 | 2-bit function select per pin |
| pin_pull_up | output | NUM_BANKS*32 | Pull-up enable per pin |
| pin_pull_dn | output | NUM_BANKS*32 | Pull-down enable per pin |
| pin_drive | output | NUM_BANKS*96 | 3-bit drive code per pin |
| pin_bias_err | output | NUM_BANKS*32 | Reserved bias code held per pin |

## Verification
The assertions assume a bus master that raises cfg_sel for one cycle per access. They also assume cfg_wr, cfg_addr and cfg_wdata are stable across the sampling edge. The bench drives all bus signals only on falling edges and drops cfg_sel between accesses, so every access is exactly one strobe cycle. The bias-exclusivity and masked-hold properties take nothing from the inputs and hold for any write pattern. The bench still aims writes at mixed masks, both pad types, both drive layouts and unmapped words, so that each property is exercised on real traffic.

// File: rtl/pinconf_pkg.sv
package pinconf_pkg;

  localparam int PINS_PER_GROUP  = 8;
  localparam int GROUPS_PER_BANK = 4;
  localparam int PINS_PER_BANK   = PINS_PER_GROUP * GROUPS_PER_BANK;
  localparam int WORD_W          = 16;
  localparam int BUS_W           = 2 * WORD_W;
  localparam int ADDR_W          = 8;
  localparam int MAX_BANKS       = 4;
  localparam int DRV_W           = 3;

  typedef enum logic [1:0] {
    RGN_FUNC = 2'd0,
    RGN_PULL = 2'd1,
    RGN_DRV  = 2'd2,
    RGN_NONE = 2'd3
  } region_e;

  typedef struct packed {
    logic up;
    logic dn;
    logic err;
  } bias_t;

  // Merge the enabled bits of new data into an old word.
  function automatic logic [WORD_W-1:0] masked_merge(
    input logic [WORD_W-1:0] old_w,
    input logic [WORD_W-1:0] data_w,
    input logic [WORD_W-1:0] en_w
  );
    return (old_w & ~en_w) | (data_w & en_w);
  endfunction

  // Bias code meaning depends on the pad type of the group.
  function automatic bias_t decode_bias(input logic low_volt, input logic [1:0] code);
    bias_t b;
    b = '0;
    if (low_volt) begin
      case (code)
        2'd1:    b.dn = 1'b1;
        2'd3:    b.up = 1'b1;
        default: b   = '0;
      endcase
    end else begin
      case (code)
        2'd1:    b.up  = 1'b1;
        2'd2:    b.dn  = 1'b1;
        2'd3:    b.err = 1'b1;
        default: b     = '0;
      endcase
    end
    return b;
  endfunction

endpackage

// File: rtl/pinconf_word.sv
module pinconf_word
  import pinconf_pkg::*;
#(
  parameter logic [WORD_W-1:0] IMPL_MASK = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wdata,
  input  logic [WORD_W-1:0] wmask,
  output logic [WORD_W-1:0] q
);

  logic [WORD_W-1:0] q_nxt;

  always_comb begin
    q_nxt = q;
    if (wr_en) begin
      q_nxt = masked_merge(q, wdata, wmask & IMPL_MASK);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (wr_en) begin
      q <= q_nxt;
    end
  end

  // Bits without a write enable in the previous cycle must keep their value.
  AST_MASKED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((q ^ $past(q)) & ~($past(wr_en) ? $past(wmask) : '0)) == '0)); // R1

  AST_UNIMPL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (q & ~IMPL_MASK) == '0); // R10

endmodule

// File: rtl/pinconf_bias_dec.sv
module pinconf_bias_dec
  import pinconf_pkg::*;
#(
  parameter bit LOW_VOLT = 1'b0
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [WORD_W-1:0]         field,
  output logic [PINS_PER_GROUP-1:0] pull_up,
  output logic [PINS_PER_GROUP-1:0] pull_dn,
  output logic [PINS_PER_GROUP-1:0] bias_err
);

  for (genvar p = 0; p < PINS_PER_GROUP; p++) begin : g_pin
    bias_t b;
    assign b           = decode_bias(LOW_VOLT, field[2*p +: 2]);
    assign pull_up[p]  = b.up;
    assign pull_dn[p]  = b.dn;
    assign bias_err[p] = b.err;
  end

  AST_PULL_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (pull_up & pull_dn) == '0); // R7

  AST_ERR_NO_PULL: assert property (@(posedge clk) disable iff (!rst_n)
    (bias_err & (pull_up | pull_dn)) == '0); // R7

  if (LOW_VOLT) begin : g_lv_chk
    AST_LV_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      bias_err == '0); // R6
  end

endmodule

// File: rtl/pinconf_drv_group.sv
module pinconf_drv_group
  import pinconf_pkg::*;
#(
  parameter bit WIDE = 1'b0
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              wr_lo,
  input  logic                              wr_hi,
  input  logic [WORD_W-1:0]                 wdata,
  input  logic [WORD_W-1:0]                 wmask,
  output logic [WORD_W-1:0]                 rd_lo,
  output logic [WORD_W-1:0]                 rd_hi,
  output logic [PINS_PER_GROUP*DRV_W-1:0]   drive
);

  localparam int WIDE_BITS = PINS_PER_GROUP * DRV_W;
  localparam int HI_BITS   = WIDE_BITS - WORD_W;
  localparam logic [WORD_W-1:0] HI_IMPL = WORD_W'((1 << HI_BITS) - 1);

  pinconf_word #(.IMPL_MASK('1)) u_lo (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (wr_lo),
    .wdata (wdata),
    .wmask (wmask),
    .q     (rd_lo)
  );

  if (WIDE) begin : g_wide
    logic [WIDE_BITS-1:0] field;

    pinconf_word #(.IMPL_MASK(HI_IMPL)) u_hi (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (wr_hi),
      .wdata (wdata),
      .wmask (wmask),
      .q     (rd_hi)
    );

    assign field = {rd_hi[HI_BITS-1:0], rd_lo};
    for (genvar p = 0; p < PINS_PER_GROUP; p++) begin : g_pin
      assign drive[DRV_W*p +: DRV_W] = field[DRV_W*p +: DRV_W];
    end
  end else begin : g_narrow
    logic unused_hi_wr;
    assign unused_hi_wr = wr_hi;
    assign rd_hi        = '0;
    for (genvar p = 0; p < PINS_PER_GROUP; p++) begin : g_pin
      assign drive[DRV_W*p +: DRV_W] = {1'b0, rd_lo[2*p +: 2]};
    end

    AST_NARROW_TOP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (drive[2] | drive[5] | drive[8] | drive[11] | drive[14] | drive[17] |
       drive[20] | drive[23]) == 1'b0); // R8
  end

endmodule

// File: rtl/pinconf_regs.sv
module pinconf_regs
  import pinconf_pkg::*;
#(
  parameter int          NUM_BANKS   = 4,
  parameter logic [15:0] LV_GROUPS   = 16'h0C03,
  parameter logic [15:0] WIDE_GROUPS = 16'h7200
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   cfg_sel,
  input  logic                                   cfg_wr,
  input  logic [7:0]                             cfg_addr,
  input  logic [31:0]                            cfg_wdata,
  output logic [31:0]                            cfg_rdata,
  output logic [NUM_BANKS*64-1:0]                pin_func,
  output logic [NUM_BANKS*32-1:0]                pin_pull_up,
  output logic [NUM_BANKS*32-1:0]                pin_pull_dn,
  output logic [NUM_BANKS*96-1:0]                pin_drive,
  output logic [NUM_BANKS*32-1:0]                pin_bias_err
);

  localparam int NUM_GROUPS = NUM_BANKS * GROUPS_PER_BANK;
  localparam int GIDX_W     = 4;

  if (NUM_BANKS < 1 || NUM_BANKS > MAX_BANKS) begin : g_bad_banks
    $error("pinconf_regs: NUM_BANKS out of range");
  end

  // ---------------- address decode ----------------
  region_e           rgn;
  logic [1:0]        dec_bank;
  logic [1:0]        dec_grp;
  logic              dec_slot;
  logic [GIDX_W-1:0] gidx;
  logic              addr_mapped;
  logic              wr_acc;
  logic              rd_acc;
  logic [WORD_W-1:0] wr_data;
  logic [WORD_W-1:0] wr_mask;

  assign wr_acc  = cfg_sel & cfg_wr;
  assign rd_acc  = cfg_sel & ~cfg_wr;
  assign wr_data = cfg_wdata[WORD_W-1:0];
  assign wr_mask = cfg_wdata[BUS_W-1:WORD_W];

  always_comb begin
    rgn      = RGN_NONE;
    dec_bank = '0;
    dec_grp  = '0;
    dec_slot = 1'b0;
    if (cfg_addr[7] == 1'b0) begin
      rgn      = cfg_addr[6] ? RGN_PULL : RGN_FUNC;
      dec_bank = cfg_addr[5:4];
      dec_grp  = cfg_addr[3:2];
    end else begin
      rgn      = RGN_DRV;
      dec_bank = cfg_addr[6:5];
      dec_grp  = cfg_addr[4:3];
      dec_slot = cfg_addr[2];
    end
    if (cfg_addr[1:0] != 2'b00 || int'(dec_bank) >= NUM_BANKS) begin
      rgn = RGN_NONE;
    end
  end

  assign gidx = {dec_bank, dec_grp};

  always_comb begin
    addr_mapped = (rgn != RGN_NONE);
    if (rgn == RGN_DRV && dec_slot && !WIDE_GROUPS[gidx]) begin
      addr_mapped = 1'b0;
    end
  end

  // ---------------- storage per group ----------------
  logic [WORD_W-1:0] func_q  [NUM_GROUPS];
  logic [WORD_W-1:0] pull_q  [NUM_GROUPS];
  logic [WORD_W-1:0] drv_lo_q[NUM_GROUPS];
  logic [WORD_W-1:0] drv_hi_q[NUM_GROUPS];

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    logic sel_g;
    logic func_we;
    logic pull_we;
    logic drv_lo_we;
    logic drv_hi_we;

    assign sel_g     = wr_acc && (gidx == GIDX_W'(g));
    assign func_we   = sel_g && (rgn == RGN_FUNC);
    assign pull_we   = sel_g && (rgn == RGN_PULL);
    assign drv_lo_we = sel_g && (rgn == RGN_DRV) && !dec_slot;
    assign drv_hi_we = sel_g && (rgn == RGN_DRV) &&  dec_slot;

    pinconf_word #(.IMPL_MASK('1)) u_func (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (func_we),
      .wdata (wr_data),
      .wmask (wr_mask),
      .q     (func_q[g])
    );

    pinconf_word #(.IMPL_MASK('1)) u_pull (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (pull_we),
      .wdata (wr_data),
      .wmask (wr_mask),
      .q     (pull_q[g])
    );

    pinconf_bias_dec #(.LOW_VOLT(LV_GROUPS[g])) u_bias (
      .clk      (clk),
      .rst_n    (rst_n),
      .field    (pull_q[g]),
      .pull_up  (pin_pull_up [g*PINS_PER_GROUP +: PINS_PER_GROUP]),
      .pull_dn  (pin_pull_dn [g*PINS_PER_GROUP +: PINS_PER_GROUP]),
      .bias_err (pin_bias_err[g*PINS_PER_GROUP +: PINS_PER_GROUP])
    );

    pinconf_drv_group #(.WIDE(WIDE_GROUPS[g])) u_drv (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_lo (drv_lo_we),
      .wr_hi (drv_hi_we),
      .wdata (wr_data),
      .wmask (wr_mask),
      .rd_lo (drv_lo_q[g]),
      .rd_hi (drv_hi_q[g]),
      .drive (pin_drive[g*PINS_PER_GROUP*DRV_W +: PINS_PER_GROUP*DRV_W])
    );

    assign pin_func[g*2*PINS_PER_GROUP +: 2*PINS_PER_GROUP] = func_q[g];
  end

  // ---------------- read path ----------------
  logic [WORD_W-1:0] rd_word;
  logic [BUS_W-1:0]  rdata_nxt;
  logic [BUS_W-1:0]  rdata_q;

  always_comb begin
    rd_word = '0;
    for (int g = 0; g < NUM_GROUPS; g++) begin
      if (gidx == GIDX_W'(g)) begin
        case (rgn)
          RGN_FUNC: rd_word = func_q[g];
          RGN_PULL: rd_word = pull_q[g];
          RGN_DRV:  rd_word = dec_slot ? drv_hi_q[g] : drv_lo_q[g];
          default:  rd_word = '0;
        endcase
      end
    end
    rdata_nxt = {{WORD_W{1'b0}}, rd_word};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (rd_acc) begin
      rdata_q <= rdata_nxt;
    end
  end

  assign cfg_rdata = rdata_q;

  AST_UNMAPPED_RD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_acc && !addr_mapped) |=> (cfg_rdata == '0)); // R10

  AST_RD_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_acc |=> (cfg_rdata[BUS_W-1:WORD_W] == '0)); // R2

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_acc |=> $stable(cfg_rdata)); // R2

endmodule

// File: tb/pinconf_regs_tb.sv
module pinconf_regs_tb_top;

  logic        clk;
  logic        rst_n;
  logic        cfg_sel;
  logic        cfg_wr;
  logic [7:0]  cfg_addr;
  logic [31:0] cfg_wdata;
  logic [31:0] cfg_rdata;
  logic [255:0] pin_func;
  logic [127:0] pin_pull_up;
  logic [127:0] pin_pull_dn;
  logic [383:0] pin_drive;
  logic [127:0] pin_bias_err;

  int tests;
  int fails;
  int cyc;
  logic rd_d;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  pinconf_regs dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_sel      (cfg_sel),
    .cfg_wr       (cfg_wr),
    .cfg_addr     (cfg_addr),
    .cfg_wdata    (cfg_wdata),
    .cfg_rdata    (cfg_rdata),
    .pin_func     (pin_func),
    .pin_pull_up  (pin_pull_up),
    .pin_pull_dn  (pin_pull_dn),
    .pin_drive    (pin_drive),
    .pin_bias_err (pin_bias_err)
  );

  initial clk = 1'b0;
  always #5ns clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [15:0] mask, input logic [15:0] data);
    @(negedge clk);
    cfg_sel   = 1'b1;
    cfg_wr    = 1'b1;
    cfg_addr  = a;
    cfg_wdata = {mask, data};
    @(negedge clk);
    cfg_sel   = 1'b0;
    cfg_wr    = 1'b0;
  endtask

  // Driver side of the scoreboard: issue a read and queue its expected data.
  task automatic bus_rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    cfg_sel  = 1'b1;
    cfg_wr   = 1'b0;
    cfg_addr = a;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    cfg_sel  = 1'b0;
  endtask

  // Monitor side: a read strobe seen at an edge has its data ready by the next falling edge.
  always @(posedge clk) rd_d <= cfg_sel && !cfg_wr;

  always @(negedge clk) begin
    if (rd_d) begin
      if (exp_q.size() == 0) begin
        tests++;
        fails++;
        $display("FAIL R2: unexpected read data 0x%0h expected none", cfg_rdata);
      end else begin
        chk(tag_q.pop_front(), cfg_rdata, exp_q.pop_front());
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 50000) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    tests     = 0;
    fails     = 0;
    cyc       = 0;
    rd_d      = 1'b0;
    rst_n     = 1'b0;
    cfg_sel   = 1'b0;
    cfg_wr    = 1'b0;
    cfg_addr  = '0;
    cfg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 reset state
    chk("R11 func", 32'(|pin_func), 32'h0);
    chk("R11 pull", 32'(|{pin_pull_up, pin_pull_dn, pin_bias_err}), 32'h0);
    chk("R11 drive", 32'(|pin_drive), 32'h0);
    bus_rd(8'h00, 32'h0, "R11 read func");
    bus_rd(8'hE4, 32'h0, "R11 read drive");

    // R3 function select: bank1 group1 pin1 -> code 2 (global pin 41)
    bus_wr(8'h14, 16'h000C, 16'h0008);
    chk("R3 pin41 func", 32'(pin_func[41*2 +: 2]), 32'd2);
    chk("R3 pin40 func", 32'(pin_func[40*2 +: 2]), 32'd0);
    bus_rd(8'h14, 32'h0000_0008, "R3 readback");

    // R1 masked write
    bus_wr(8'h14, 16'h0003, 16'hFFFF);
    bus_rd(8'h14, 32'h0000_000B, "R1 partial mask");
    bus_wr(8'h14, 16'h0000, 16'hFFFF);
    bus_rd(8'h14, 32'h0000_000B, "R1 zero mask");
    chk("R1 pin41 kept", 32'(pin_func[41*2 +: 2]), 32'd2);

    // R4 / R5 default pad: bank1 group0 pins 32..35 codes 0,1,2,3
    bus_wr(8'h50, 16'h00FF, 16'h00E4);
    bus_rd(8'h50, 32'h0000_00E4, "R4 bias readback");
    chk("R5 pin32 float", {29'd0, pin_pull_up[32], pin_pull_dn[32], pin_bias_err[32]}, 32'b000);
    chk("R5 pin33 up",    {29'd0, pin_pull_up[33], pin_pull_dn[33], pin_bias_err[33]}, 32'b100);
    chk("R5 pin34 down",  {29'd0, pin_pull_up[34], pin_pull_dn[34], pin_bias_err[34]}, 32'b010);
    chk("R7 pin35 rsvd",  {29'd0, pin_pull_up[35], pin_pull_dn[35], pin_bias_err[35]}, 32'b001);

    // R6 low-voltage pad: bank0 group0 pins 0..3 codes 0,1,2,3
    bus_wr(8'h40, 16'h00FF, 16'h00E4);
    chk("R6 pin0 float", {29'd0, pin_pull_up[0], pin_pull_dn[0], pin_bias_err[0]}, 32'b000);
    chk("R6 pin1 down",  {29'd0, pin_pull_up[1], pin_pull_dn[1], pin_bias_err[1]}, 32'b010);
    chk("R6 pin2 float", {29'd0, pin_pull_up[2], pin_pull_dn[2], pin_bias_err[2]}, 32'b000);
    chk("R6 pin3 up",    {29'd0, pin_pull_up[3], pin_pull_dn[3], pin_bias_err[3]}, 32'b100);

    // R12 same code 1 in a low-voltage group (pin 80) and a default group (pin 72)
    bus_wr(8'h68, 16'h0003, 16'h0001);
    bus_wr(8'h64, 16'h0003, 16'h0001);
    chk("R12 pin80 lv down",   {30'd0, pin_pull_up[80], pin_pull_dn[80]}, 32'b01);
    chk("R12 pin72 def up",    {30'd0, pin_pull_up[72], pin_pull_dn[72]}, 32'b10);

    // R7 reserved code replaced by pull-down clears the flag
    bus_wr(8'h50, 16'h00C0, 16'h0080);
    chk("R7 pin35 cleared", {29'd0, pin_pull_up[35], pin_pull_dn[35], pin_bias_err[35]}, 32'b010);

    // R8 narrow drive: bank1 group2 pin7 code 3 (global pin 55)
    bus_wr(8'hB0, 16'hC000, 16'hC000);
    chk("R8 pin55 drive", 32'(pin_drive[55*3 +: 3]), 32'd3);
    bus_rd(8'hB0, 32'h0000_C000, "R8 readback");
    bus_wr(8'hB4, 16'hFFFF, 16'hFFFF);
    bus_rd(8'hB4, 32'h0, "R10 narrow second slot");
    chk("R10 pin55 unchanged", 32'(pin_drive[55*3 +: 3]), 32'd3);

    // R9 wide drive: bank3 group0, pin5 straddles the slot boundary (global 101)
    bus_wr(8'hE0, 16'h8000, 16'h8000);
    chk("R9 pin101 low part", 32'(pin_drive[101*3 +: 3]), 32'd1);
    bus_wr(8'hE4, 16'h0003, 16'h0003);
    chk("R9 pin101 full", 32'(pin_drive[101*3 +: 3]), 32'd7);
    bus_wr(8'hE4, 16'h00E0, 16'h00A0);
    chk("R9 pin103 high", 32'(pin_drive[103*3 +: 3]), 32'd5);
    bus_rd(8'hE4, 32'h0000_00A3, "R9 second slot readback");
    bus_wr(8'hE4, 16'hFF00, 16'hFF00);
    bus_rd(8'hE4, 32'h0000_00A3, "R10 wide upper byte");

    // R10 misaligned access
    bus_wr(8'h15, 16'hFFFF, 16'h0000);
    bus_rd(8'h14, 32'h0000_000B, "R10 misaligned write ignored");
    bus_rd(8'h15, 32'h0, "R10 misaligned read");

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      tests++;
      fails++;
      $display("FAIL R2: actual %0d reads pending expected 0", exp_q.size());
    end
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule